// File: doc/BRIEF.md
# Tag-Renaming Out-of-Order Integer Scheduler

This block is a small out-of-order issue and execute engine for integer operations. Decoded operations arrive in program order on a single issue port. Each one is placed into a free reservation station of its class, adder or multiplier. Its source operands are taken either as values from the register file or as tags that name the station that will produce them. A register status table records, for each architectural register, the tag of the station that last claimed it as a destination. WAR and WAW hazards are removed by this renaming and are never checked.

Each class has one pipelined functional unit with a parameterized latency. A station is dispatched to its unit once both operands hold values. The unit's result is parked back in the station until it gets the single common result bus. Each cycle the bus carries one tag and value. Waiting stations and register entries that match the tag capture the value in that same cycle. An operation that issues while its producer is on the bus takes the value directly at issue. A register read port lets the surrounding logic observe architectural state and pending status.

Top module: `rs_sched`

## Requirements
- R1: After reset every register r holds the value r, no register is pending, the result bus is idle (cdb_valid 0) and in_ready is 1 for every opcode.
- R2: Opcodes 00 (add), 01 (subtract) and 11 (xor) use adder stations, tags 1..N_ADD. Opcode 10 (multiply) uses multiplier stations, tags N_ADD+1..N_ADD+N_MUL. Issue takes the lowest-numbered free station of the class.
- R3: in_ready is 0 when every station of the opcode's class is busy, independent of the other class, and no operation is accepted while it is 0.
- R4: An operation whose operands are both available at issue appears on the result bus exactly LAT+2 cycles after its issue cycle (ADD_LAT for adder ops, MUL_LAT for multiplies).
- R5: Results are the low XLEN bits of a+b, a-b, a*b or a^b, where a is source 1 and b is source 2.
- R6: At most one result is broadcast per cycle. When several stations hold results, the lowest tag is granted and the others keep their result and retry the next cycle.
- R7: rd_pending of a register is 1 from the issue of a writer until its most recent writer broadcasts. A register value changes only when the broadcast tag equals its recorded writer, so an older writer finishing late does not overwrite it.
- R8: A station waiting on a tag captures the value when that tag is broadcast, and it then executes with the captured value.
- R9: An operation that issues in the cycle its producer broadcasts captures the operand at issue. It completes LAT+2 cycles after issue without waiting for a second broadcast.
- R10: Every accepted operation is broadcast exactly once, and its station becomes free in the cycle of that broadcast.
- R11: After all operations drain, the register file equals sequential in-order execution of the accepted operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered for issue |
| in_op | input | 2 | Opcode: 00 add, 01 subtract, 10 multiply, 11 xor |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| in_ready | output | 1 | A station of the offered opcode's class is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | $clog2(N_ADD+N_MUL+1) | Tag of the broadcasting station |
| cdb_value | output | XLEN | Broadcast result value |
| rd_idx | input | $clog2(NREG) | Register read index |
| rd_value | output | XLEN | Current value of register rd_idx |
| rd_pending | output | 1 | Register rd_idx awaits a pending writer |

## Verification
The bench builds the default configuration: eight 16-bit registers, three adder stations, two multiplier stations, adder latency 1 and multiplier latency 3. With so few stations, a single multiply followed by three dependent adds fills the adder class. The two-cycle latency gap lets an add and a multiply issued two cycles apart tie on the bus, which exercises the lowest-tag grant. Eight registers make pseudo-random streams full of RAW, WAR and WAW collisions, and each stream is compared register by register against an in-order arithmetic model.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_XOR = 2'b11
  } op_e;

  function automatic logic op_is_mul(input logic [1:0] op);
    return op == OP_MUL;
  endfunction
endpackage

// File: rtl/rs_exec_pipe.sv
module rs_exec_pipe
  import rs_pkg::*;
#(
  parameter int LAT  = 1,
  parameter int XLEN = 16,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [TW-1:0]   tag,
  output logic            out_valid,
  output logic [TW-1:0]   out_tag,
  output logic [XLEN-1:0] out_val
);
  localparam int DEPTH = (LAT < 1) ? 1 : LAT;

  logic [XLEN-1:0] res_c;
  logic [DEPTH-1:0] v_q, v_d;
  logic [TW-1:0]    t_q [DEPTH];
  logic [TW-1:0]    t_d [DEPTH];
  logic [XLEN-1:0]  r_q [DEPTH];
  logic [XLEN-1:0]  r_d [DEPTH];

  always_comb begin
    case (op)
      OP_ADD:  res_c = a + b;
      OP_SUB:  res_c = a - b;
      OP_MUL:  res_c = a * b;
      default: res_c = a ^ b;
    endcase
  end

  always_comb begin
    v_d[0] = start;
    t_d[0] = tag;
    r_d[0] = res_c;
    for (int s = 1; s < DEPTH; s++) begin
      v_d[s] = v_q[s-1];
      t_d[s] = t_q[s-1];
      r_d[s] = r_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        t_q[s] <= '0;
        r_q[s] <= '0;
      end
    end else begin
      v_q <= v_d;
      for (int s = 0; s < DEPTH; s++) begin
        t_q[s] <= t_d[s];
        r_q[s] <= r_d[s];
      end
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_tag   = t_q[DEPTH-1];
  assign out_val   = r_q[DEPTH-1];
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int XLEN = 16,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_en,
  input  logic [1:0]      iss_op,
  input  logic [XLEN-1:0] iss_vj,
  input  logic [XLEN-1:0] iss_vk,
  input  logic [TW-1:0]   iss_qj,
  input  logic [TW-1:0]   iss_qk,
  input  logic            cdb_valid,
  input  logic [TW-1:0]   cdb_tag,
  input  logic [XLEN-1:0] cdb_value,
  input  logic            disp_gnt,
  input  logic            fin_en,
  input  logic [XLEN-1:0] fin_val,
  input  logic            bus_gnt,
  output logic            busy,
  output logic            rdy,
  output logic            done,
  output logic [1:0]      op,
  output logic [XLEN-1:0] vj,
  output logic [XLEN-1:0] vk,
  output logic [XLEN-1:0] res
);
  logic            busy_q, busy_d, exec_q, exec_d, done_q, done_d;
  logic [1:0]      op_q, op_d;
  logic [XLEN-1:0] vj_q, vj_d, vk_q, vk_d, res_q, res_d;
  logic [TW-1:0]   qj_q, qj_d, qk_q, qk_d;

  always_comb begin
    busy_d = busy_q; exec_d = exec_q; done_d = done_q; op_d = op_q;
    vj_d = vj_q; vk_d = vk_q; qj_d = qj_q; qk_d = qk_q; res_d = res_q;
    if (iss_en) begin
      busy_d = 1'b1; exec_d = 1'b0; done_d = 1'b0; op_d = iss_op;
      vj_d = iss_vj; vk_d = iss_vk; qj_d = iss_qj; qk_d = iss_qk;
    end else if (busy_q) begin
      if (cdb_valid && qj_q != '0 && cdb_tag == qj_q) begin
        vj_d = cdb_value; qj_d = '0;
      end
      if (cdb_valid && qk_q != '0 && cdb_tag == qk_q) begin
        vk_d = cdb_value; qk_d = '0;
      end
      if (disp_gnt) exec_d = 1'b1;
      if (fin_en) begin
        done_d = 1'b1; res_d = fin_val;
      end
      if (bus_gnt) begin
        busy_d = 1'b0; exec_d = 1'b0; done_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; exec_q <= 1'b0; done_q <= 1'b0; op_q <= '0;
      vj_q <= '0; vk_q <= '0; qj_q <= '0; qk_q <= '0; res_q <= '0;
    end else begin
      busy_q <= busy_d; exec_q <= exec_d; done_q <= done_d; op_q <= op_d;
      vj_q <= vj_d; vk_q <= vk_d; qj_q <= qj_d; qk_q <= qk_d; res_q <= res_d;
    end
  end

  assign busy = busy_q;
  assign rdy  = busy_q && !exec_q && qj_q == '0 && qk_q == '0;
  assign done = done_q;
  assign op   = op_q;
  assign vj   = vj_q;
  assign vk   = vk_q;
  assign res  = res_q;

  // R8
  operand_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !iss_en && cdb_valid && qj_q != '0 && cdb_tag == qj_q)
      |=> (qj_q == '0 && vj_q == $past(cdb_value)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !bus_gnt && !iss_en) |=> (done_q && $stable(res_q)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(bus_gnt && done_q));
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  parameter int TW   = 3,
  parameter int RW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_en,
  input  logic [RW-1:0]   iss_dst,
  input  logic [TW-1:0]   iss_tag,
  input  logic [RW-1:0]   src1,
  input  logic [RW-1:0]   src2,
  input  logic            cdb_valid,
  input  logic [TW-1:0]   cdb_tag,
  input  logic [XLEN-1:0] cdb_value,
  input  logic [RW-1:0]   rd_idx,
  output logic [XLEN-1:0] s1_v,
  output logic [TW-1:0]   s1_q,
  output logic [XLEN-1:0] s2_v,
  output logic [TW-1:0]   s2_q,
  output logic [XLEN-1:0] rd_value,
  output logic            rd_pending
);
  logic [XLEN-1:0] val_q [NREG];
  logic [XLEN-1:0] val_d [NREG];
  logic [TW-1:0]   qi_q  [NREG];
  logic [TW-1:0]   qi_d  [NREG];
  logic [NREG-1:0] wr_en;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      wr_en[i] = cdb_valid && qi_q[i] != '0 && qi_q[i] == cdb_tag;
      val_d[i] = wr_en[i] ? cdb_value : val_q[i];
      qi_d[i]  = wr_en[i] ? '0 : qi_q[i];
    end
    if (iss_en) qi_d[iss_dst] = iss_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        val_q[i] <= XLEN'(i);
        qi_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_en[i]) val_q[i] <= val_d[i];
        qi_q[i] <= qi_d[i];
      end
    end
  end

  always_comb begin
    s1_v = val_q[src1];
    s1_q = qi_q[src1];
    if (qi_q[src1] != '0 && cdb_valid && cdb_tag == qi_q[src1]) begin
      s1_v = cdb_value; s1_q = '0;
    end
    s2_v = val_q[src2];
    s2_q = qi_q[src2];
    if (qi_q[src2] != '0 && cdb_valid && cdb_tag == qi_q[src2]) begin
      s2_v = cdb_value; s2_q = '0;
    end
  end

  assign rd_value   = val_q[rd_idx];
  assign rd_pending = qi_q[rd_idx] != '0;

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    // R7
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(val_q[g]) |-> ($past(cdb_valid) && $past(cdb_tag) == $past(qi_q[g])));
  end
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int XLEN    = 16,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  input  logic [1:0]                        in_op,
  input  logic [$clog2(NREG)-1:0]           in_dst,
  input  logic [$clog2(NREG)-1:0]           in_src1,
  input  logic [$clog2(NREG)-1:0]           in_src2,
  output logic                              in_ready,
  output logic                              cdb_valid,
  output logic [$clog2(N_ADD+N_MUL+1)-1:0]  cdb_tag,
  output logic [XLEN-1:0]                   cdb_value,
  input  logic [$clog2(NREG)-1:0]           rd_idx,
  output logic [XLEN-1:0]                   rd_value,
  output logic                              rd_pending
);
  localparam int NST = N_ADD + N_MUL;
  localparam int TW  = $clog2(NST + 1);
  localparam int RW  = $clog2(NREG);

  logic [NST-1:0]  st_busy, st_rdy, st_done, bus_gnt;
  logic [1:0]      st_op  [NST];
  logic [XLEN-1:0] st_vj  [NST];
  logic [XLEN-1:0] st_vk  [NST];
  logic [XLEN-1:0] st_res [NST];

  logic            want_mul, fire;
  logic            a_free, m_free;
  logic [TW-1:0]   a_free_tag, m_free_tag, iss_tag;
  logic [XLEN-1:0] s1_v, s2_v;
  logic [TW-1:0]   s1_q, s2_q;

  logic            a_hit, m_hit;
  logic [TW-1:0]   a_tag, m_tag;
  logic [1:0]      a_op, m_op;
  logic [XLEN-1:0] a_vj, a_vk, m_vj, m_vk;
  logic            a_out_v, m_out_v;
  logic [TW-1:0]   a_out_tag, m_out_tag;
  logic [XLEN-1:0] a_out_val, m_out_val;

  // Issue: lowest free station of the operation's class
  always_comb begin
    a_free = 1'b0; a_free_tag = '0;
    for (int i = N_ADD - 1; i >= 0; i--) begin
      if (!st_busy[i]) begin a_free = 1'b1; a_free_tag = TW'(i + 1); end
    end
    m_free = 1'b0; m_free_tag = '0;
    for (int i = NST - 1; i >= N_ADD; i--) begin
      if (!st_busy[i]) begin m_free = 1'b1; m_free_tag = TW'(i + 1); end
    end
  end

  assign want_mul = op_is_mul(in_op);
  assign in_ready = want_mul ? m_free : a_free;
  assign fire     = in_valid && in_ready;
  assign iss_tag  = want_mul ? m_free_tag : a_free_tag;

  // Dispatch: lowest ready station per class feeds its unit
  always_comb begin
    a_hit = 1'b0; a_tag = '0; a_op = OP_ADD; a_vj = '0; a_vk = '0;
    for (int i = N_ADD - 1; i >= 0; i--) begin
      if (st_rdy[i]) begin
        a_hit = 1'b1; a_tag = TW'(i + 1); a_op = st_op[i]; a_vj = st_vj[i]; a_vk = st_vk[i];
      end
    end
    m_hit = 1'b0; m_tag = '0; m_op = OP_MUL; m_vj = '0; m_vk = '0;
    for (int i = NST - 1; i >= N_ADD; i--) begin
      if (st_rdy[i]) begin
        m_hit = 1'b1; m_tag = TW'(i + 1); m_op = st_op[i]; m_vj = st_vj[i]; m_vk = st_vk[i];
      end
    end
  end

  // Result bus: lowest tag among finished stations wins
  always_comb begin
    int win;
    win = -1;
    for (int i = NST - 1; i >= 0; i--) begin
      if (st_done[i]) win = i;
    end
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0;
    for (int i = 0; i < NST; i++) begin
      bus_gnt[i] = (i == win);
      if (i == win) begin
        cdb_valid = 1'b1; cdb_tag = TW'(i + 1); cdb_value = st_res[i];
      end
    end
  end

  rs_exec_pipe #(.LAT(ADD_LAT), .XLEN(XLEN), .TW(TW)) u_add_pipe (
    .clk, .rst_n, .start(a_hit), .op(a_op), .a(a_vj), .b(a_vk), .tag(a_tag),
    .out_valid(a_out_v), .out_tag(a_out_tag), .out_val(a_out_val)
  );

  rs_exec_pipe #(.LAT(MUL_LAT), .XLEN(XLEN), .TW(TW)) u_mul_pipe (
    .clk, .rst_n, .start(m_hit), .op(m_op), .a(m_vj), .b(m_vk), .tag(m_tag),
    .out_valid(m_out_v), .out_tag(m_out_tag), .out_val(m_out_val)
  );

  rs_regstat #(.NREG(NREG), .XLEN(XLEN), .TW(TW), .RW(RW)) u_regs (
    .clk, .rst_n, .iss_en(fire), .iss_dst(in_dst), .iss_tag(iss_tag),
    .src1(in_src1), .src2(in_src2),
    .cdb_valid, .cdb_tag, .cdb_value, .rd_idx,
    .s1_v, .s1_q, .s2_v, .s2_q, .rd_value, .rd_pending
  );

  for (genvar g = 0; g < NST; g++) begin : g_st
    localparam logic [TW-1:0] MYTAG  = TW'(g + 1);
    localparam bit            IS_MUL = (g >= N_ADD);
    logic fin_en, disp_gnt;
    assign fin_en   = IS_MUL ? (m_out_v && m_out_tag == MYTAG) : (a_out_v && a_out_tag == MYTAG);
    assign disp_gnt = IS_MUL ? (m_hit && m_tag == MYTAG) : (a_hit && a_tag == MYTAG);

    rs_station #(.XLEN(XLEN), .TW(TW)) u_st (
      .clk, .rst_n,
      .iss_en(fire && iss_tag == MYTAG), .iss_op(in_op),
      .iss_vj(s1_v), .iss_vk(s2_v), .iss_qj(s1_q), .iss_qk(s2_q),
      .cdb_valid, .cdb_tag, .cdb_value,
      .disp_gnt, .fin_en, .fin_val(IS_MUL ? m_out_val : a_out_val),
      .bus_gnt(bus_gnt[g]),
      .busy(st_busy[g]), .rdy(st_rdy[g]), .done(st_done[g]),
      .op(st_op[g]), .vj(st_vj[g]), .vk(st_vk[g]), .res(st_res[g])
    );
  end

  // R6
  bus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_gnt & st_done) && (cdb_valid == (st_done != '0)));
endmodule

// File: tb/tb_rs_sched.sv
`timescale 1ns/1ps
module tb_rs_sched;
  localparam int NREG = 8, XLEN = 16, N_ADD = 3, N_MUL = 2, ADD_LAT = 1, MUL_LAT = 3;
  localparam int TW = 3, RW = 3;
  localparam int BCN = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_ready, cdb_valid, rd_pending;
  logic [1:0] in_op;
  logic [RW-1:0] in_dst, in_src1, in_src2, rd_idx;
  logic [TW-1:0] cdb_tag;
  logic [XLEN-1:0] cdb_value, rd_value;

  rs_sched #(.NREG(NREG), .XLEN(XLEN), .N_ADD(N_ADD), .N_MUL(N_MUL),
             .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)) dut (
    .clk, .rst_n, .in_valid, .in_op, .in_dst, .in_src1, .in_src2, .in_ready,
    .cdb_valid, .cdb_tag, .cdb_value, .rd_idx, .rd_value, .rd_pending
  );

  int total = 0, bad = 0, cyc = 0, bc_n = 0, base = 0, issued = 0;
  bit finished = 0;
  int bc_cyc [BCN];
  int bc_tag [BCN];
  int bc_val [BCN];
  logic [XLEN-1:0] mreg [NREG];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && cdb_valid === 1'b1) begin
      bc_cyc[bc_n % BCN] = cyc;
      bc_tag[bc_n % BCN] = int'(cdb_tag);
      bc_val[bc_n % BCN] = int'(cdb_value);
      bc_n = bc_n + 1;
    end
  end

  function automatic int bi(input int k);
    return (base + k) % BCN;
  endfunction

  function automatic logic [XLEN-1:0] model_op(input logic [1:0] op, input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    case (op)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return a * b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int d, input int s1, input int s2, output int icyc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op;
    in_dst = RW'(d); in_src1 = RW'(s1); in_src2 = RW'(s2);
    #1;
    while (in_ready !== 1'b1) begin
      @(negedge clk); #1;
    end
    icyc = cyc;
    mreg[d] = model_op(op, mreg[s1], mreg[s2]);
    issued++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(60);
  endtask

  task automatic read_reg(input int i, output int v, output int p);
    @(negedge clk);
    rd_idx = RW'(i);
    #1;
    v = int'(rd_value);
    p = int'(rd_pending);
  endtask

  task automatic compare_regs(input string req);
    int v, p;
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, v, p);
      chk(req, v, int'(mreg[i]));
      chk({req, " pending"}, p, 0);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, t2, t3, v, p, n0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00;
    in_dst = '0; in_src1 = '0; in_src2 = '0; rd_idx = '0;
    for (int i = 0; i < NREG; i++) mreg[i] = XLEN'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, v, p);
      chk("R1 reset value", v, i);
      chk("R1 reset pending", p, 0);
    end
    chk("R1 bus idle", int'(cdb_valid), 0);
    in_op = 2'b00; #1; chk("R1 ready add", int'(in_ready), 1);
    in_op = 2'b10; #1; chk("R1 ready mul", int'(in_ready), 1);

    // R4 R5 R2: independent add
    base = bc_n;
    issue(2'b00, 1, 2, 3, t0);
    drain();
    chk("R10 one broadcast", bc_n - base, 1);
    chk("R4 add latency", bc_cyc[bi(0)] - t0, ADD_LAT + 2);
    chk("R2 add tag", bc_tag[bi(0)], 1);
    chk("R5 add value", bc_val[bi(0)], int'(mreg[1]));

    // R4 R5 R2: independent multiply
    base = bc_n;
    issue(2'b10, 2, 3, 1, t0);
    drain();
    chk("R4 mul latency", bc_cyc[bi(0)] - t0, MUL_LAT + 2);
    chk("R2 mul tag", bc_tag[bi(0)], N_ADD + 1);
    chk("R5 mul value", bc_val[bi(0)], int'(mreg[2]));
    compare_regs("R5 regs");

    // R6 tie: multiply then add two cycles later finish together
    base = bc_n;
    issue(2'b10, 5, 2, 3, t0);
    idle(1);
    issue(2'b00, 6, 1, 2, t1);
    drain();
    chk("R6 issue spacing", t1 - t0, 2);
    chk("R6 count", bc_n - base, 2);
    chk("R6 winner tag", bc_tag[bi(0)], 1);
    chk("R6 winner cycle", bc_cyc[bi(0)] - t0, MUL_LAT + 2);
    chk("R6 loser tag", bc_tag[bi(1)], N_ADD + 1);
    chk("R6 loser retry cycle", bc_cyc[bi(1)] - t0, MUL_LAT + 3);
    compare_regs("R6 regs");

    // R3 R8 R7: adder class filled by consumers of a pending multiply
    base = bc_n;
    issue(2'b10, 1, 2, 3, t0);
    issue(2'b00, 4, 1, 2, t1);
    issue(2'b01, 5, 1, 3, t2);
    issue(2'b11, 6, 1, 1, t3);
    @(negedge clk);
    in_valid = 1'b0;
    in_op = 2'b00; #1;
    chk("R3 adder full ready", int'(in_ready), 0);
    in_op = 2'b10; #1;
    chk("R3 mul free ready", int'(in_ready), 1);
    chk("R3 cycle", cyc - t0, 4);
    chk("R8 no broadcast yet", bc_n - base, 0);
    rd_idx = 3'd4; #1;
    chk("R7 pending", int'(rd_pending), 1);
    drain();
    chk("R8 count", bc_n - base, 4);
    chk("R8 first mul tag", bc_tag[bi(0)], N_ADD + 1);
    chk("R2 adder tag a", bc_tag[bi(1)], 1);
    chk("R2 adder tag b", bc_tag[bi(2)], 2);
    chk("R2 adder tag c", bc_tag[bi(3)], 3);
    compare_regs("R8 regs");

    // R7 WAW: slow older writer finishes after younger writer
    base = bc_n;
    issue(2'b10, 5, 2, 3, t0);
    issue(2'b00, 5, 6, 7, t1);
    drain();
    chk("R7 count", bc_n - base, 2);
    read_reg(5, v, p);
    chk("R7 last writer wins", v, int'(mreg[5]));
    chk("R7 cleared", p, 0);
    compare_regs("R7 regs");

    // R9 issue in the producer's broadcast cycle
    base = bc_n;
    issue(2'b00, 1, 2, 3, t0);
    idle(2);
    issue(2'b00, 4, 1, 1, t1);
    drain();
    chk("R9 issue cycle", t1 - t0, ADD_LAT + 2);
    chk("R9 producer cycle", bc_cyc[bi(0)] - t0, ADD_LAT + 2);
    chk("R9 consumer tag", bc_tag[bi(1)], 2);
    chk("R9 consumer latency", bc_cyc[bi(1)] - t1, ADD_LAT + 2);
    chk("R9 consumer value", bc_val[bi(1)], int'(mreg[4]));

    // R11 R10 pseudo-random streams
    for (int r = 0; r < 40; r++) begin
      base = bc_n;
      n0 = issued;
      for (int k = 0; k < 50; k++) begin
        step_lfsr();
        if (lfsr[15:13] == 3'd0) idle(1 + int'(lfsr[1:0]));
        issue(lfsr[1:0], int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]), t0);
      end
      drain();
      chk("R10 broadcasts equal issues", bc_n - base, issued - n0);
      compare_regs("R11 in-order equivalence");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule